// File: doc/BRIEF.md
# 64-bit Free-Running Timer with Compare Channel

This block keeps a 64-bit up-counter that software can start, stop and preload one 32-bit half at a time. It compares the counter against a 64-bit compare value. On a match it latches a pending flag and drives a level interrupt when that flag is enabled. In auto-increment mode, each match adds a programmed 32-bit step to the compare value, so interrupts recur at a fixed period. Without auto-increment, the compare value stays put and the match fires once.

Writes to the counter halves, the compare halves, the step and the control word do not take effect at once. Each write is staged and applied a fixed number of cycles after the bus strobe, `APPLY_DLY`, which models the settling time of a slower timer domain. When the write lands, the block sets a sticky write-status bit for that register. Software clears the bit by writing 1 to it. Reads are combinational and show the applied values. The counter keeps running between reads, so software can take a high, low, high sequence of reads and retry when the two high words differ.

Top module: `tmr_cmp64`

## Requirements
- R1: While the run bit (bit 8 of the control word at 0x240) is set, the counter advances by one on every clock. While the run bit is clear, the counter holds its value. The low word reads at 0x100 and the high word at 0x104.
- R2: A write to 0x100 or 0x104 replaces only that half of the counter. The write is applied exactly `APPLY_DLY` clocks after the strobe. In the same edge it sets bit 0 (low half) or bit 1 (high half) of the counter write-status word at 0x110.
- R3: Writes to the compare low word (0x200), the compare high word (0x204), the step (0x208) and the control word (0x240) are applied exactly `APPLY_DLY` clocks after the strobe. Until then, a read returns the old value. On application, the write sets bit 0, bit 1, bit 2 or bit 16 respectively of the write-status word at 0x24C.
- R4: Writing 1 to a write-status bit clears it. Writing 0 to it leaves it set.
- R5: When the run bit and the compare-enable bit (bit 0 of 0x240) are both set and all 64 counter bits equal the compare value, the pending flag (bit 0 of 0x244) is set on the next edge.
- R6: With auto-increment (bit 1 of 0x240) set, every match adds the step to the compare value. Matches therefore recur exactly step clocks apart.
- R7: With auto-increment clear, a match leaves the compare value unchanged. After the pending flag is cleared, no further interrupt follows.
- R8: The interrupt output equals the pending flag ANDed with the enable bit (bit 0 of 0x248). Writing 1 to bit 0 of 0x244 clears the pending flag. Clearing the enable bit hides the flag from the output but leaves it set.
- R9: The counter wraps from all ones to zero. A compare value of zero matches on the wrap.
- R10: After reset, every register, every status bit and the interrupt output are zero.
- R11: No match is recorded while the run bit or the compare-enable bit is clear, even if the counter equals the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a match on the wrap from all ones to zero. The stimulus preloads both counter halves to eight counts below the top while the counter is stopped, leaves the compare value at its reset value of zero, and then starts the counter. A second delicate case is the exact period in auto-increment mode: the bench counts clocks between two interrupt assertions, with a pending-flag clear placed between them. It also reads back a delayed write one cycle before and at the cycle it is applied.

// File: rtl/tmr_cmp64.sv
module tmr_cmp64 #(
  parameter int APPLY_DLY = 4,
  parameter int AW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);

  localparam int NSLOT = 6;
  localparam int DW    = $clog2(APPLY_DLY + 1);

  localparam logic [AW-1:0] A_CNT_LO = AW'('h100);
  localparam logic [AW-1:0] A_CNT_HI = AW'('h104);
  localparam logic [AW-1:0] A_CWST   = AW'('h110);
  localparam logic [AW-1:0] A_CMP_LO = AW'('h200);
  localparam logic [AW-1:0] A_CMP_HI = AW'('h204);
  localparam logic [AW-1:0] A_STEP   = AW'('h208);
  localparam logic [AW-1:0] A_CTRL   = AW'('h240);
  localparam logic [AW-1:0] A_IST    = AW'('h244);
  localparam logic [AW-1:0] A_IEN    = AW'('h248);
  localparam logic [AW-1:0] A_WST    = AW'('h24C);

  localparam int S_CLO = 0, S_CHI = 1, S_MLO = 2, S_MHI = 3, S_STP = 4, S_CTL = 5;

  function automatic logic [AW-1:0] slot_addr(input int i);
    case (i)
      S_CLO:   return A_CNT_LO;
      S_CHI:   return A_CNT_HI;
      S_MLO:   return A_CMP_LO;
      S_MHI:   return A_CMP_HI;
      S_STP:   return A_STEP;
      default: return A_CTRL;
    endcase
  endfunction

  logic [NSLOT-1:0] sel, pend, fire;
  logic [31:0]      stg [NSLOT];
  logic [DW-1:0]    dly [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign sel[g]  = bus_wr && (bus_addr == slot_addr(g));
    assign fire[g] = pend[g] && (dly[g] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
        dly[g]  <= '0;
        stg[g]  <= '0;
      end else if (sel[g]) begin
        pend[g] <= 1'b1;
        dly[g]  <= DW'(APPLY_DLY - 1);
        stg[g]  <= bus_wdata;
      end else if (pend[g]) begin
        if (dly[g] == '0) pend[g] <= 1'b0;
        else              dly[g]  <= dly[g] - 1'b1;
      end
    end
  end

  logic [63:0] cnt, cmp;
  logic [31:0] step;
  logic        run, autoinc, cmp_en, ist, ien;
  logic [1:0]  cwst;
  logic [3:0]  wst;
  logic        hit;

  assign hit = run && cmp_en && (cnt == cmp);
  assign irq = ist && ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (fire[S_CLO] || fire[S_CHI]) begin
      cnt <= {fire[S_CHI] ? stg[S_CHI] : cnt[63:32],
              fire[S_CLO] ? stg[S_CLO] : cnt[31:0]};
    end else if (run) begin
      cnt <= cnt + 64'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
    end else if (fire[S_MLO] || fire[S_MHI]) begin
      cmp <= {fire[S_MHI] ? stg[S_MHI] : cmp[63:32],
              fire[S_MLO] ? stg[S_MLO] : cmp[31:0]};
    end else if (hit && autoinc) begin
      cmp <= cmp + {32'd0, step};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= '0;
      run     <= 1'b0;
      autoinc <= 1'b0;
      cmp_en  <= 1'b0;
      ien     <= 1'b0;
      ist     <= 1'b0;
    end else begin
      if (fire[S_STP]) step <= stg[S_STP];
      if (fire[S_CTL]) begin
        run     <= stg[S_CTL][8];
        autoinc <= stg[S_CTL][1];
        cmp_en  <= stg[S_CTL][0];
      end
      if (bus_wr && bus_addr == A_IEN) ien <= bus_wdata[0];
      ist <= hit || (ist && !(bus_wr && bus_addr == A_IST && bus_wdata[0]));
    end
  end

  logic [1:0] cwst_clr;
  logic [3:0] wst_clr;
  assign cwst_clr = (bus_wr && bus_addr == A_CWST) ? bus_wdata[1:0] : 2'b00;
  assign wst_clr  = (bus_wr && bus_addr == A_WST)
                    ? {bus_wdata[16], bus_wdata[2:0]} : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwst <= '0;
      wst  <= '0;
    end else begin
      cwst <= (cwst & ~cwst_clr) | {fire[S_CHI], fire[S_CLO]};
      wst  <= (wst & ~wst_clr) | {fire[S_CTL], fire[S_STP], fire[S_MHI], fire[S_MLO]};
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt[31:0];
      A_CNT_HI: bus_rdata = cnt[63:32];
      A_CWST:   bus_rdata = {30'd0, cwst};
      A_CMP_LO: bus_rdata = cmp[31:0];
      A_CMP_HI: bus_rdata = cmp[63:32];
      A_STEP:   bus_rdata = step;
      A_CTRL:   bus_rdata = {23'd0, run, 6'd0, autoinc, cmp_en};
      A_IST:    bus_rdata = {31'd0, ist};
      A_IEN:    bus_rdata = {31'd0, ien};
      A_WST:    bus_rdata = {15'd0, wst[3], 13'd0, wst[2:0]};
      default:  bus_rdata = '0;
    endcase
  end

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fire[S_CLO] && !fire[S_CHI]) |=> cnt == $past(cnt) + 64'd1);

  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !fire[S_CLO] && !fire[S_CHI]) |=> $stable(cnt));

  p_cnt_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire[S_CLO] |=> cwst[0]);

  p_ctl_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire[S_CTL] |=> wst[3]);

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_WST && bus_wdata[16] && !fire[S_CTL]) |=> !wst[3]);

  p_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ist);

  p_autoinc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && autoinc && !fire[S_MLO] && !fire[S_MHI])
    |=> cmp == $past(cmp) + {32'd0, $past(step)});

  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !autoinc && !fire[S_MLO] && !fire[S_MHI]) |=> $stable(cmp));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ien);

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '1 && !fire[S_CLO] && !fire[S_CHI]) |=> cnt == '0);

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ist && !(run && cmp_en)) |=> !ist);

endmodule

// File: tb/sim_tmr_cmp64.sv
`timescale 1ns/1ps
module sim_tmr_cmp64;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_cmp64 #(.APPLY_DLY(D), .AW(12)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  localparam int NV = 7;
  localparam logic [11:0] T_ADDR [NV] = '{12'h208, 12'h200, 12'h204, 12'h240, 12'h104, 12'h100, 12'h248};
  localparam logic [31:0] T_DATA [NV] = '{32'h10, 32'h1234, 32'h5, 32'h3, 32'hA, 32'h77, 32'h1};
  localparam logic [11:0] T_SADR [NV] = '{12'h24C, 12'h24C, 12'h24C, 12'h24C, 12'h110, 12'h110, 12'h110};
  localparam logic [31:0] T_MASK [NV] = '{32'h4, 32'h1, 32'h2, 32'h10000, 32'h2, 32'h1, 32'h0};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_irq(input int lim, output int k);
    k = 0;
    while (!irq && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    logic [31:0] v, a, b;
    int k;

    do_reset();
    // R10 reset state
    chk("R10 irq", irq, 0);
    rd(12'h100, v); chk("R10 cnt_lo", v, 0);
    rd(12'h200, v); chk("R10 cmp_lo", v, 0);
    rd(12'h240, v); chk("R10 ctrl", v, 0);
    rd(12'h24C, v); chk("R10 wstat", v, 0);
    rd(12'h110, v); chk("R10 cnt wstat", v, 0);

    // R2 R3 R4 table walk: write, wait apply delay, read back, check and clear status
    for (int i = 0; i < NV; i++) begin
      wr(T_ADDR[i], T_DATA[i]);
      repeat (D) @(negedge clk);
      rd(T_ADDR[i], v); chk("R2/R3 readback", v, T_DATA[i]);
      if (T_MASK[i] != 0) begin
        rd(T_SADR[i], v); chk("R2/R3 status set", v & T_MASK[i], T_MASK[i]);
        wr(T_SADR[i], T_MASK[i]);
        rd(T_SADR[i], v); chk("R4 status cleared", v & T_MASK[i], 0);
      end
    end

    // R3 exact apply cycle, R4 zero write keeps status
    do_reset();
    wr(12'h208, 32'h20);
    repeat (D - 1) @(negedge clk);
    rd(12'h208, v); chk("R3 before apply", v, 0);
    @(negedge clk);
    rd(12'h208, v); chk("R3 at apply", v, 32'h20);
    wr(12'h24C, 32'h0);
    rd(12'h24C, v); chk("R4 zero write keeps bit", v, 32'h4);

    // R1 counting and holding
    do_reset();
    wr(12'h100, 32'd100);
    wr(12'h240, 32'h100);
    repeat (D + 2) @(negedge clk);
    rd(12'h100, a);
    repeat (10) @(negedge clk);
    rd(12'h100, b);
    chk("R1 advance by 10", b - a, 10);
    wr(12'h240, 32'h0);
    repeat (D + 1) @(negedge clk);
    rd(12'h100, a);
    repeat (5) @(negedge clk);
    rd(12'h100, b);
    chk("R1 hold when stopped", b, a);

    // R5 R7 one-shot match
    do_reset();
    wr(12'h200, 32'd50);
    wr(12'h248, 32'h1);
    wr(12'h240, 32'h101);
    wait_irq(300, k);
    chk("R5 match raises irq", irq, 1);
    rd(12'h200, v); chk("R7 compare unchanged", v, 50);
    wr(12'h244, 32'h1);
    chk("R8 clear pending", irq, 0);
    repeat (100) @(negedge clk);
    chk("R7 no second irq", irq, 0);

    // R6 periodic, R8 enable gating
    do_reset();
    wr(12'h208, 32'd40);
    wr(12'h200, 32'd30);
    wr(12'h248, 32'h1);
    wr(12'h240, 32'h103);
    wait_irq(300, k);
    chk("R6 first irq", irq, 1);
    wr(12'h244, 32'h1);
    k = 1;
    while (!irq && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk("R6 period", k, 40);
    rd(12'h200, v); chk("R6 compare advanced twice", v, 110);
    wr(12'h248, 32'h0);
    chk("R8 irq masked", irq, 0);
    rd(12'h244, v); chk("R8 pending kept", v, 1);

    // R9 wrap match at zero
    do_reset();
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFF8);
    wr(12'h248, 32'h1);
    wr(12'h240, 32'h101);
    wait_irq(60, k);
    chk("R9 irq on wrap", irq, 1);
    rd(12'h104, v); chk("R9 high word wrapped", v, 0);

    // R11 no match when stopped or compare disabled
    do_reset();
    wr(12'h248, 32'h1);
    wr(12'h240, 32'h1);
    repeat (20) @(negedge clk);
    chk("R11 stopped no match", irq, 0);
    wr(12'h200, 32'd20);
    wr(12'h240, 32'h100);
    repeat (100) @(negedge clk);
    rd(12'h244, v); chk("R11 disabled no match", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule